// File: doc/BRIEF.md
# Masked Multichannel Conversion Sequencer

This block sequences one group of eight simultaneously sampled converter channels. A configuration word holds a per-channel enable mask. A start pulse freezes a sample of every channel on one clock edge. The block then walks through the enabled channels only, spending a fixed number of clock cycles on each, and stores one 12-bit result per enabled channel. Disabled channels cost no time and leave no slot in the readback order.

Software reads the results through a single data port. Each read returns the next enabled channel, lowest channel number first. Two flags follow the sequence. One rises when the first enabled result is ready, and the other rises when the last one is. The analog front end is modelled by a packed sample bus, and the per-channel conversion time is a cycle count. The first-result delay and the per-channel step are parameters: 100 and 25 cycles, which is 800 ns and 200 ns at 125 MHz.

Top module: `mcs_seq`

## Requirements
- R1: A configuration write sets the enable mask from cfg_wdata bits 7:0, where bit k enables channel k when 1. Bits 15:8 of the write are ignored. cfg_rdata always reads {8'hFF, mask}.
- R2: After reset the mask is 8'hFF, so cfg_rdata reads 16'hFFFF, and both flags are 0.
- R3: On the clock edge where start is sampled high, the sample bus is captured for every channel. Later changes of the bus do not affect the results of that run. Channel k occupies samp_in[12k+11:12k].
- R4: With at least one channel enabled, eoc is 0 until the FIRST_DLY-th clock edge after the start edge, and it is 1 after that edge.
- R5: With n enabled channels, eolc becomes 1 after the edge FIRST_DLY + (n-1)*STEP_DLY edges after the start edge, and it is 0 before that edge. Each disabled channel therefore shortens the run by STEP_DLY cycles.
- R6: Once set, each flag stays set until the next start. eolc is never 1 while eoc is 0.
- R7: After a run, successive reads (rd_en high for one cycle each) return the enabled channels in ascending channel order. Each read returns {4'hF, result}, with the result in bits 11:0 and bit 0 as its LSB.
- R8: A read at or beyond the last enabled channel returns that channel's result again, and the read position does not move.
- R9: A start clears both flags on the following cycle and returns the read position to the lowest enabled channel.
- R10: If the mask is zero at start, both flags are 1 on the next cycle and rd_data reads 16'hFFFF.
- R11: A configuration write while a run is in progress changes cfg_rdata but does not change the timing or the readback of the run that is already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write word |
| cfg_rdata | output | 16 | Configuration readback |
| start | input | 1 | Start-conversion pulse |
| samp_in | input | 96 | Packed sample bus, 12 bits per channel |
| rd_en | input | 1 | Data read strobe; moves the read position |
| rd_data | output | 16 | Current result word |
| eoc | output | 1 | First enabled result ready |
| eolc | output | 1 | Last enabled result ready |

## Verification
The hardest situation to reach from the ports is a run whose enable set differs from the live mask. This happens when the mask is rewritten mid-run. The stimulus starts a run on the low four channels and then writes a mask that enables only the high four. It then checks that eolc still lands at the four-channel time and that readback still returns channels 0 to 3. A second hard case is a restart after a partial readback. The bench reads one result, starts again with fresh samples, and checks that the flags clear and that the first read after the new run is the lowest channel's new value.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int unsigned BUS_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_NEXT  = 2'd2
    } conv_state_e;

    typedef struct packed {
        logic eoc;
        logic eolc;
    } conv_flags_t;

endpackage

// File: rtl/mcs_cfg_reg.sv
module mcs_cfg_reg #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned BUS_W = 16,
    localparam int unsigned CNT_W = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [BUS_W-1:0] cfg_wdata,
    output logic [BUS_W-1:0] cfg_rdata,
    output logic [NCH-1:0]   mask,
    output logic [CNT_W-1:0] en_cnt
);

    logic unused_hi;
    assign unused_hi = ^cfg_wdata[BUS_W-1:NCH];

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '1;
        else if (cfg_we)
            mask <= cfg_wdata[NCH-1:0];
    end

    assign cfg_rdata = {{(BUS_W-NCH){1'b1}}, mask};

    always_comb begin
        en_cnt = '0;
        for (int i = 0; i < NCH; i++)
            en_cnt = en_cnt + CNT_W'(mask[i]);
    end

endmodule

// File: rtl/mcs_conv_ctrl.sv
module mcs_conv_ctrl
    import mcs_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter int unsigned FIRST_DLY = 100,
    parameter int unsigned STEP_DLY  = 25,
    localparam int unsigned CNT_W  = $clog2(NCH + 1),
    localparam int unsigned SLOT_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned MAXD   = (FIRST_DLY > STEP_DLY) ? FIRST_DLY : STEP_DLY,
    localparam int unsigned TMR_W  = $clog2(MAXD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [CNT_W-1:0]  run_cnt,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output conv_flags_t       flags
);

    conv_state_e       state;
    logic [TMR_W-1:0]  tmr;
    logic [SLOT_W-1:0] slot;
    logic              is_last;

    assign wr_en   = (state != ST_IDLE) && (tmr == '0) && !start;
    assign wr_slot = slot;
    assign is_last = (CNT_W'(slot) + CNT_W'(1)) == run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            slot    <= '0;
            run_cnt <= CNT_W'(NCH);
            flags   <= '0;
        end else if (start) begin
            run_cnt <= live_cnt;
            slot    <= '0;
            if (live_cnt == '0) begin
                state <= ST_IDLE;
                tmr   <= '0;
                flags <= '{eoc: 1'b1, eolc: 1'b1};
            end else begin
                state <= ST_FIRST;
                tmr   <= TMR_W'(FIRST_DLY - 1);
                flags <= '0;
            end
        end else if (wr_en) begin
            flags.eoc <= 1'b1;
            if (is_last) begin
                flags.eolc <= 1'b1;
                state      <= ST_IDLE;
            end else begin
                state <= ST_NEXT;
                tmr   <= TMR_W'(STEP_DLY - 1);
                slot  <= slot + SLOT_W'(1);
            end
        end else if (state != ST_IDLE) begin
            tmr <= tmr - TMR_W'(1);
        end
    end

endmodule

// File: rtl/mcs_result_store.sv
module mcs_result_store #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned RES_W = 12,
    parameter int unsigned BUS_W = 16,
    localparam int unsigned CNT_W  = $clog2(NCH + 1),
    localparam int unsigned SLOT_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NCH-1:0]     mask,
    input  logic [NCH*RES_W-1:0] samp_in,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [CNT_W-1:0]   run_cnt,
    input  logic               rd_en,
    output logic [BUS_W-1:0]   rd_data
);

    logic [RES_W-1:0]  staged [NCH];
    logic [RES_W-1:0]  result [NCH];
    logic [RES_W-1:0]  picked [NCH];
    logic [SLOT_W-1:0] rd_ptr;

    // For each slot k, select the sample of the k-th enabled channel.
    for (genvar k = 0; k < NCH; k++) begin : g_pick
        always_comb begin
            logic [CNT_W-1:0] seen;
            seen      = '0;
            picked[k] = '0;
            for (int c = 0; c < NCH; c++) begin
                if (mask[c]) begin
                    if (seen == CNT_W'(k))
                        picked[k] = samp_in[c*RES_W +: RES_W];
                    seen = seen + CNT_W'(1);
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                staged[k] <= '0;
                result[k] <= '0;
            end else begin
                if (start)
                    staged[k] <= picked[k];
                if (wr_en && wr_slot == SLOT_W'(k))
                    result[k] <= staged[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start)
            rd_ptr <= '0;
        else if (rd_en && ((CNT_W'(rd_ptr) + CNT_W'(1)) < run_cnt))
            rd_ptr <= rd_ptr + SLOT_W'(1);
    end

    assign rd_data = (run_cnt == '0) ? '1 : {{(BUS_W-RES_W){1'b1}}, result[rd_ptr]};

endmodule

// File: rtl/mcs_seq.sv
module mcs_seq
    import mcs_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter int unsigned RES_W     = 12,
    parameter int unsigned FIRST_DLY = 100,
    parameter int unsigned STEP_DLY  = 25,
    localparam int unsigned CNT_W  = $clog2(NCH + 1),
    localparam int unsigned SLOT_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [BUS_W-1:0]     cfg_wdata,
    output logic [BUS_W-1:0]     cfg_rdata,
    input  logic                 start,
    input  logic [NCH*RES_W-1:0] samp_in,
    input  logic                 rd_en,
    output logic [BUS_W-1:0]     rd_data,
    output logic                 eoc,
    output logic                 eolc
);

    logic [NCH-1:0]    mask;
    logic [CNT_W-1:0]  live_cnt;
    logic [CNT_W-1:0]  run_cnt;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    conv_flags_t       flags;

    mcs_cfg_reg #(.NCH(NCH), .BUS_W(BUS_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mask      (mask),
        .en_cnt    (live_cnt)
    );

    mcs_conv_ctrl #(.NCH(NCH), .FIRST_DLY(FIRST_DLY), .STEP_DLY(STEP_DLY)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .live_cnt (live_cnt),
        .run_cnt  (run_cnt),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .flags    (flags)
    );

    mcs_result_store #(.NCH(NCH), .RES_W(RES_W), .BUS_W(BUS_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mask    (mask),
        .samp_in (samp_in),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .run_cnt (run_cnt),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    assign eoc  = flags.eoc;
    assign eolc = flags.eolc;

endmodule

// File: rtl/mcs_seq_chk.sv
module mcs_seq_chk #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned BUS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [BUS_W-1:0] cfg_rdata,
    input logic [BUS_W-1:0] rd_data,
    input logic             eoc,
    input logic             eolc
);

    AST_CFG_HIGH_ONES: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[BUS_W-1:NCH] == '1);                                  // R1

    AST_RD_HIGH_ONES: assert property (@(posedge clk) disable iff (rst)
        rd_data[BUS_W-1:12] == '1);                                     // R7

    AST_EOLC_NEEDS_EOC: assert property (@(posedge clk) disable iff (rst)
        eolc |-> eoc);                                                  // R6

    AST_EOC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (eoc && !start) |=> eoc);                                       // R6

    AST_EOLC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (eolc && !start) |=> eolc);                                     // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && cfg_rdata[NCH-1:0] != '0) |=> (!eoc && !eolc));       // R9

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
        (start && cfg_rdata[NCH-1:0] == '0) |=> (eoc && eolc && rd_data == '1)); // R10

endmodule

bind mcs_seq mcs_seq_chk #(.NCH(NCH), .BUS_W(mcs_pkg::BUS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_rdata (cfg_rdata),
    .rd_data   (rd_data),
    .eoc       (eoc),
    .eolc      (eolc)
);

// File: tb/mcs_seq_tb.sv
module mcs_seq_tb;

    localparam int NCH = 8;
    localparam int RW  = 12;
    localparam int FD  = 100;
    localparam int SD  = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          start = 1'b0;
    logic [NCH*RW-1:0] samp_in = '0;
    logic          rd_en = 1'b0;
    logic [15:0]   rd_data;
    logic          eoc, eolc;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    logic [RW-1:0] vals [NCH];
    logic [RW-1:0] held [NCH];

    always #4 clk = ~clk;

    mcs_seq #(.NCH(NCH), .RES_W(RW), .FIRST_DLY(FD), .STEP_DLY(SD)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .start(start), .samp_in(samp_in),
        .rd_en(rd_en), .rd_data(rd_data), .eoc(eoc), .eolc(eolc)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nth_chan(input logic [7:0] m, input int k);
        int seen = 0;
        for (int c = 0; c < NCH; c++)
            if (m[c]) begin
                if (seen == k) return c;
                seen++;
            end
        return -1;
    endfunction

    function automatic int ones(input logic [7:0] m);
        int n = 0;
        for (int c = 0; c < NCH; c++) n += int'(m[c]);
        return n;
    endfunction

    task automatic drive_samples(input int seed);
        for (int k = 0; k < NCH; k++) begin
            vals[k] = RW'(seed * 37 + k * 291 + 5);
            samp_in[k*RW +: RW] = vals[k];
        end
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Leaves time half a cycle after the start edge; samples change after it.
    task automatic pulse_start(input int seed);
        drive_samples(seed);
        for (int k = 0; k < NCH; k++) held[k] = vals[k];
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        drive_samples(seed + 1000);   // R3: later bus changes must not matter
    endtask

    // Called right after pulse_start; checks R4/R5 timing for n enabled channels.
    task automatic wait_flags(input int n, input string tag);
        repeat (FD - 1) @(negedge clk);
        chk(eoc == 1'b0, {tag, " R4 eoc early"}, 16'(eoc), 16'd0);
        @(negedge clk);
        chk(eoc == 1'b1, {tag, " R4 eoc on time"}, 16'(eoc), 16'd1);
        if (n > 1) begin
            chk(eolc == 1'b0, {tag, " R5 eolc early"}, 16'(eolc), 16'd0);
            repeat ((n - 1) * SD - 1) @(negedge clk);
            chk(eolc == 1'b0, {tag, " R5 eolc one before"}, 16'(eolc), 16'd0);
            @(negedge clk);
        end
        chk(eolc == 1'b1, {tag, " R5 eolc on time"}, 16'(eolc), 16'd1);
    endtask

    task automatic read_chk(input logic [15:0] exp, input string tag);
        @(negedge clk);
        chk(rd_data == exp, tag, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_all(input logic [7:0] m, input string tag);
        int n = ones(m);
        for (int k = 0; k < n; k++)
            read_chk({4'hF, held[nth_chan(m, k)]}, {tag, " R7 order"});
        read_chk({4'hF, held[nth_chan(m, n - 1)]}, {tag, " R8 past end"});
        read_chk({4'hF, held[nth_chan(m, n - 1)]}, {tag, " R8 holds"});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cfg_rdata == 16'hFFFF, "R2 cfg reset", cfg_rdata, 16'hFFFF);
        chk(eoc == 1'b0, "R2 eoc reset", 16'(eoc), 16'd0);
        chk(eolc == 1'b0, "R2 eolc reset", 16'(eolc), 16'd0);
    endtask

    task automatic t_full();
        pulse_start(1);
        wait_flags(8, "full");
        read_all(8'hFF, "full R3");
    endtask

    task automatic t_masked();
        wr_cfg(16'hAB21);
        @(negedge clk);
        chk(cfg_rdata == 16'hFF21, "R1 high bits ignored", cfg_rdata, 16'hFF21);
        pulse_start(2);
        wait_flags(2, "mask21");
        read_all(8'h21, "mask21");
    endtask

    task automatic t_single();
        wr_cfg(16'h0080);
        pulse_start(3);
        wait_flags(1, "single");
        read_all(8'h80, "single");
    endtask

    task automatic t_restart();
        wr_cfg(16'h0090);
        pulse_start(4);
        wait_flags(2, "restart1");
        read_chk({4'hF, held[4]}, "restart R7 first");
        pulse_start(5);
        chk(eoc == 1'b0, "R9 eoc cleared", 16'(eoc), 16'd0);
        chk(eolc == 1'b0, "R9 eolc cleared", 16'(eolc), 16'd0);
        repeat (FD + SD) @(negedge clk);
        read_chk({4'hF, held[4]}, "R9 pointer back to lowest");
        read_chk({4'hF, held[7]}, "R9 second after restart");
    endtask

    task automatic t_empty();
        wr_cfg(16'hFF00);
        pulse_start(6);
        chk(eoc == 1'b1, "R10 eoc", 16'(eoc), 16'd1);
        chk(eolc == 1'b1, "R10 eolc", 16'(eolc), 16'd1);
        chk(rd_data == 16'hFFFF, "R10 rd_data", rd_data, 16'hFFFF);
        read_chk(16'hFFFF, "R10 after read");
    endtask

    task automatic t_midwrite();
        wr_cfg(16'h000F);
        pulse_start(7);
        wr_cfg(16'h00F0);
        chk(cfg_rdata == 16'hFFF0, "R11 cfg updates", cfg_rdata, 16'hFFF0);
        repeat (FD + 3 * SD - 1 - 2) @(negedge clk);
        chk(eolc == 1'b0, "R11 eolc not early", 16'(eolc), 16'd0);
        @(negedge clk);
        chk(eolc == 1'b1, "R11 eolc at 4-channel time", 16'(eolc), 16'd1);
        read_all(8'h0F, "R11 run keeps old mask");
    endtask

    initial begin
        drive_samples(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full();
        t_masked();
        t_single();
        t_restart();
        t_empty();
        t_midwrite();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule